// File: doc/BRIEF.md
# GPIO Register Bank with Alias Addresses

This block holds the programming state of a 16-bit general purpose port and makes it reachable over a simple synchronous register bus. The bus has a select, a write enable, a byte address, 16-bit write data and registered read data. Eight storage registers hold the state: pin data, two interrupt enable masks (A and B), and five pin configuration registers (direction, polarity, edge select, both-edge select and input enable). Every storage register drives a dedicated output, so the pin sampling and interrupt logic outside the block always sees the current configuration.

The data register and each of the two masks can be changed in three extra ways besides a full load. Each of them owns a clear address, a set address and a toggle address. Software can therefore flip single bits without a read-modify-write sequence. A read at any of these alias addresses returns the register that the alias acts on.

The pin sampling logic can reload the data register through its own update strobe. A bus access at an address outside the map, or at an address that is not aligned to a word, does not change any register. It reads as zero, and it sets a sticky error output that only reset clears.

Top module: `gpio_alias_regbank`

## Requirements
- R1: After reset, all eight configuration outputs, the read data and the error output are zero.
- R2: Register index = byte offset / 4. Index 0 is data, 4 is mask A, 8 is mask B, 12 is direction, 13 is polarity, 14 is edge select, 15 is both-edge select and 16 is input enable. A write at one of these indices replaces the whole register, and the new value appears on the matching output on the clock edge that takes the write.
- R3: Indices 1, 5 and 9 are the clear aliases of data, mask A and mask B. A write there clears each register bit that is 1 in the write data and leaves the other bits unchanged.
- R4: Indices 2, 6 and 10 are the set aliases of data, mask A and mask B. A write there ORs the write data into the register.
- R5: Indices 3, 7 and 11 are the toggle aliases of data, mask A and mask B. A write there XORs the write data into the register.
- R6: A read at any valid index returns the register's value from before the read edge, one cycle later. A read at indices 0 to 3 returns data, at 4 to 7 mask A, and at 8 to 11 mask B. The read data holds between reads.
- R7: An access is invalid when the offset is above 64 or when its two low address bits are not zero. An invalid access changes no register and reads as zero. It sets the error output from the next cycle on, and the output stays set until reset.
- R8: When the pin update strobe is high and no valid bus write targets indices 0 to 3 in the same cycle, the data register takes the pin update value on that edge. A bus write to any other register in the same cycle still takes effect.
- R9: When a valid bus write to indices 0 to 3 and a pin update arrive in the same cycle, the bus write decides every bit of the data register and the pin value is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| busSel | input | 1 | Bus access in this cycle |
| busWe | input | 1 | 1 for write, 0 for read |
| busAddr | input | ADDR_W (8) | Byte offset of the access |
| busWdata | input | DATA_W (16) | Write data |
| busRdata | output | DATA_W (16) | Registered read data |
| busError | output | 1 | Sticky flag for an invalid access |
| pinUpdValid | input | 1 | Pin logic reloads the data register |
| pinUpdData | input | DATA_W (16) | Value from the pin logic |
| cfgData | output | DATA_W (16) | Data register |
| cfgMaskA | output | DATA_W (16) | Mask A register |
| cfgMaskB | output | DATA_W (16) | Mask B register |
| cfgDir | output | DATA_W (16) | Direction register |
| cfgPolar | output | DATA_W (16) | Polarity register |
| cfgEdge | output | DATA_W (16) | Edge-select register |
| cfgBoth | output | DATA_W (16) | Both-edge register |
| cfgInen | output | DATA_W (16) | Input-enable register |

## Verification
Every result is due one clock edge after its stimulus. A write, an alias operation or a pin update shows on the configuration outputs after the edge that takes it. Read data arrives one edge after the read, and the error flag rises one edge after the invalid access. Stimulus is driven on the falling edge. The scoreboard queues the expected read value when it issues a read and pops it on the following falling edge, and the output checks also wait for that falling edge. A result is therefore sampled half a cycle after the edge that produced it, and before the next stimulus can change it.

// File: rtl/gpio_rb_pkg.sv
package gpio_rb_pkg;

  localparam int REG_W     = 16;
  localparam int NUM_STORE = 8;
  localparam int NUM_IDX   = 17;
  localparam int ALIAS_END = 12;  // first index past the alias groups
  localparam int PLAIN_TGT = 3;   // target code of the first plain register

  typedef enum logic [2:0] {
    TGT_DATA  = 3'd0,
    TGT_MASKA = 3'd1,
    TGT_MASKB = 3'd2,
    TGT_DIR   = 3'd3,
    TGT_POLAR = 3'd4,
    TGT_EDGE  = 3'd5,
    TGT_BOTH  = 3'd6,
    TGT_INEN  = 3'd7
  } regTgtE;

  typedef enum logic [1:0] {
    OP_LOAD = 2'd0,
    OP_CLR  = 2'd1,
    OP_SET  = 2'd2,
    OP_TGL  = 2'd3
  } wrOpE;

  // strobes from the decoder to the datapath
  typedef struct packed {
    logic   wrEn;   // valid write
    logic   rdEn;   // any read, valid or not
    logic   bad;    // access outside the map or misaligned
    wrOpE   op;
    regTgtE tgt;
  } busStrobeT;

endpackage

// File: rtl/gpio_rb_decode.sv
module gpio_rb_decode
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  output busStrobeT         strb,
  output logic              errSticky
);

  localparam int IDX_W = ADDR_W - 2;

  logic [IDX_W-1:0] idx;
  logic [IDX_W-1:0] relIdx;
  logic             aligned;
  logic             inMap;

  assign idx     = busAddr[ADDR_W-1:2];
  assign aligned = (busAddr[1:0] == 2'b00);
  assign inMap   = (idx < IDX_W'(NUM_IDX));
  assign relIdx  = idx - IDX_W'(ALIAS_END - PLAIN_TGT);

  always_comb begin
    strb = '0;
    if (busSel) begin
      strb.rdEn = !busWe;
      if (!aligned || !inMap) begin
        strb.bad = 1'b1;
      end else begin
        strb.wrEn = busWe;
        if (idx < IDX_W'(ALIAS_END)) begin
          strb.tgt = regTgtE'({1'b0, idx[3:2]});
          strb.op  = wrOpE'(idx[1:0]);
        end else begin
          strb.tgt = regTgtE'(relIdx[2:0]);
          strb.op  = OP_LOAD;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)         errSticky <= 1'b0;
    else if (strb.bad) errSticky <= 1'b1;
  end

endmodule

// File: rtl/gpio_rb_datapath.sv
module gpio_rb_datapath
  import gpio_rb_pkg::*;
#(
  parameter int DATA_W = REG_W
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  busStrobeT                          strb,
  input  logic [DATA_W-1:0]                  wdata,
  input  logic                               pinUpdValid,
  input  logic [DATA_W-1:0]                  pinUpdData,
  output logic [DATA_W-1:0]                  rdata,
  output logic [NUM_STORE-1:0][DATA_W-1:0]   regsOut
);

  logic [DATA_W-1:0] store [NUM_STORE];

  function automatic logic [DATA_W-1:0] applyOp(wrOpE op, logic [DATA_W-1:0] cur,
                                                logic [DATA_W-1:0] val);
    logic [DATA_W-1:0] res;
    unique case (op)
      OP_CLR:  res = cur & ~val;
      OP_SET:  res = cur | val;
      OP_TGL:  res = cur ^ val;
      default: res = val;
    endcase
    return res;
  endfunction

  for (genvar g = 0; g < NUM_STORE; g++) begin : gStore
    logic hit;
    assign hit = strb.wrEn && (strb.tgt == regTgtE'(g));
    if (g == int'(TGT_DATA)) begin : gPinFed
      // bus write wins over a pin update in the same cycle
      always_ff @(posedge clk) begin
        if (!rstN)            store[g] <= '0;
        else if (hit)         store[g] <= applyOp(strb.op, store[g], wdata);
        else if (pinUpdValid) store[g] <= pinUpdData;
      end
    end else begin : gBusOnly
      always_ff @(posedge clk) begin
        if (!rstN)    store[g] <= '0;
        else if (hit) store[g] <= applyOp(strb.op, store[g], wdata);
      end
    end
    assign regsOut[g] = store[g];
  end

  always_ff @(posedge clk) begin
    if (!rstN)          rdata <= '0;
    else if (strb.rdEn) rdata <= strb.bad ? '0 : store[strb.tgt];
  end

endmodule

// File: rtl/gpio_alias_regbank.sv
module gpio_alias_regbank
  import gpio_rb_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = REG_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              busSel,
  input  logic              busWe,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic [DATA_W-1:0] busWdata,
  output logic [DATA_W-1:0] busRdata,
  output logic              busError,
  input  logic              pinUpdValid,
  input  logic [DATA_W-1:0] pinUpdData,
  output logic [DATA_W-1:0] cfgData,
  output logic [DATA_W-1:0] cfgMaskA,
  output logic [DATA_W-1:0] cfgMaskB,
  output logic [DATA_W-1:0] cfgDir,
  output logic [DATA_W-1:0] cfgPolar,
  output logic [DATA_W-1:0] cfgEdge,
  output logic [DATA_W-1:0] cfgBoth,
  output logic [DATA_W-1:0] cfgInen
);

  busStrobeT                         strb;
  logic [NUM_STORE-1:0][DATA_W-1:0]  regsOut;

  gpio_rb_decode #(.ADDR_W(ADDR_W)) uDecode (
    .clk      (clk),
    .rstN     (rstN),
    .busSel   (busSel),
    .busWe    (busWe),
    .busAddr  (busAddr),
    .strb     (strb),
    .errSticky(busError)
  );

  gpio_rb_datapath #(.DATA_W(DATA_W)) uPath (
    .clk        (clk),
    .rstN       (rstN),
    .strb       (strb),
    .wdata      (busWdata),
    .pinUpdValid(pinUpdValid),
    .pinUpdData (pinUpdData),
    .rdata      (busRdata),
    .regsOut    (regsOut)
  );

  assign cfgData  = regsOut[TGT_DATA];
  assign cfgMaskA = regsOut[TGT_MASKA];
  assign cfgMaskB = regsOut[TGT_MASKB];
  assign cfgDir   = regsOut[TGT_DIR];
  assign cfgPolar = regsOut[TGT_POLAR];
  assign cfgEdge  = regsOut[TGT_EDGE];
  assign cfgBoth  = regsOut[TGT_BOTH];
  assign cfgInen  = regsOut[TGT_INEN];

endmodule

// File: rtl/gpio_rb_chk.sv
module gpio_rb_chk #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              busSel,
  input logic              busWe,
  input logic [ADDR_W-1:0] busAddr,
  input logic [DATA_W-1:0] busWdata,
  input logic [DATA_W-1:0] busRdata,
  input logic              busError,
  input logic              pinUpdValid,
  input logic [DATA_W-1:0] pinUpdData,
  input logic [DATA_W-1:0] cfgData,
  input logic [DATA_W-1:0] cfgMaskA,
  input logic [DATA_W-1:0] cfgMaskB,
  input logic [DATA_W-1:0] cfgDir
);

  logic busWr;
  assign busWr = busSel && busWe;

  // R3
  data_clr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(4) |=> cfgData == ($past(cfgData) & ~$past(busWdata)));

  // R4
  maska_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(24) |=> cfgMaskA == ($past(cfgMaskA) | $past(busWdata)));

  // R5
  maskb_tgl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(44) |=> cfgMaskB == ($past(cfgMaskB) ^ $past(busWdata)));

  // R6
  alias_read_chk: assert property (@(posedge clk) disable iff (!rstN)
    busSel && !busWe && busAddr == ADDR_W'(8) |=> busRdata == $past(cfgData));

  // R7
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    busError |=> busError);

  // R7
  bad_wr_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(68) && !pinUpdValid |=>
      $stable(cfgData) && $stable(cfgDir) && busError);

  // R8
  pin_load_chk: assert property (@(posedge clk) disable iff (!rstN)
    pinUpdValid && !(busWr && busAddr < ADDR_W'(16)) |=> cfgData == $past(pinUpdData));

  // R9
  bus_wins_chk: assert property (@(posedge clk) disable iff (!rstN)
    busWr && busAddr == ADDR_W'(0) |=> cfgData == $past(busWdata));

endmodule

bind gpio_alias_regbank gpio_rb_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) uChk (
  .clk        (clk),
  .rstN       (rstN),
  .busSel     (busSel),
  .busWe      (busWe),
  .busAddr    (busAddr),
  .busWdata   (busWdata),
  .busRdata   (busRdata),
  .busError   (busError),
  .pinUpdValid(pinUpdValid),
  .pinUpdData (pinUpdData),
  .cfgData    (cfgData),
  .cfgMaskA   (cfgMaskA),
  .cfgMaskB   (cfgMaskB),
  .cfgDir     (cfgDir)
);

// File: tb/tb_gpio_alias_regbank.sv
`timescale 1ns/1ps
module tb_gpio_alias_regbank;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busSel = 1'b0, busWe = 1'b0;
  logic [7:0]  busAddr = '0;
  logic [15:0] busWdata = '0, pinUpdData = '0;
  logic        pinUpdValid = 1'b0;
  logic [15:0] busRdata, cfgData, cfgMaskA, cfgMaskB, cfgDir, cfgPolar, cfgEdge, cfgBoth, cfgInen;
  logic        busError;

  always #10 clk = ~clk;  // 50 MHz

  gpio_alias_regbank dut (
    .clk(clk), .rstN(rstN), .busSel(busSel), .busWe(busWe), .busAddr(busAddr),
    .busWdata(busWdata), .busRdata(busRdata), .busError(busError),
    .pinUpdValid(pinUpdValid), .pinUpdData(pinUpdData),
    .cfgData(cfgData), .cfgMaskA(cfgMaskA), .cfgMaskB(cfgMaskB), .cfgDir(cfgDir),
    .cfgPolar(cfgPolar), .cfgEdge(cfgEdge), .cfgBoth(cfgBoth), .cfgInen(cfgInen)
  );

  int          nChecks = 0, nFails = 0;
  logic [15:0] mdl [8];
  logic        mdlErr = 1'b0;
  logic [15:0] expQ [$];
  string       tagQ [$];
  logic        rdPend = 1'b0;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected read value one edge after the read
  always @(posedge clk) rdPend <= busSel && !busWe;
  always @(negedge clk) begin
    if (rdPend) begin
      if (expQ.size() == 0) begin
        nChecks++; nFails++;
        $display("FAIL R6: actual %h expected <none>", busRdata);
      end else begin
        chk(busRdata, expQ.pop_front(), tagQ.pop_front());
      end
    end
  end

  function automatic logic [15:0] applyMdl(int op, logic [15:0] cur, logic [15:0] v);
    case (op)
      1: return cur & ~v;
      2: return cur | v;
      3: return cur ^ v;
      default: return v;
    endcase
  endfunction

  // driver: one cycle, called at a falling edge
  task automatic drive(input bit sel, input bit we, input logic [7:0] addr,
                       input logic [15:0] wv, input bit pv, input logic [15:0] pd,
                       input string tag);
    int  idx, tgt, op;
    bit  bad, dataWr;
    idx = int'(addr) >> 2;
    bad = (addr[1:0] != 2'b00) || idx > 16;
    tgt = (idx < 12) ? idx / 4 : idx - 9;
    op  = (idx < 12) ? idx % 4 : 0;
    dataWr = 1'b0;
    busSel = sel; busWe = we; busAddr = addr; busWdata = wv;
    pinUpdValid = pv; pinUpdData = pd;
    if (sel) begin
      if (bad) begin
        mdlErr = 1'b1;
        if (!we) begin expQ.push_back(16'h0); tagQ.push_back(tag); end
      end else if (!we) begin
        expQ.push_back(mdl[tgt]); tagQ.push_back(tag);
      end else begin
        mdl[tgt] = applyMdl(op, mdl[tgt], wv);
        dataWr = (tgt == 0);
      end
    end
    if (pv && !dataWr) mdl[0] = pd;
    @(posedge clk);
    @(negedge clk);
    busSel = 1'b0; busWe = 1'b0; pinUpdValid = 1'b0;
  endtask

  task automatic wr(input logic [7:0] a, input logic [15:0] v, input string tag);
    drive(1'b1, 1'b1, a, v, 1'b0, 16'h0, tag);
  endtask

  task automatic rd(input logic [7:0] a, input string tag);
    drive(1'b1, 1'b0, a, 16'h0, 1'b0, 16'h0, tag);
  endtask

  task automatic checkAll(input string tag);
    chk(cfgData,  mdl[0], tag); chk(cfgMaskA, mdl[1], tag);
    chk(cfgMaskB, mdl[2], tag); chk(cfgDir,   mdl[3], tag);
    chk(cfgPolar, mdl[4], tag); chk(cfgEdge,  mdl[5], tag);
    chk(cfgBoth,  mdl[6], tag); chk(cfgInen,  mdl[7], tag);
    chk({15'h0, busError}, {15'h0, mdlErr}, tag);
  endtask

  initial begin
    #2_000_000;
    nChecks++; nFails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    for (int i = 0; i < 8; i++) mdl[i] = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state
    checkAll("R1");
    chk(busRdata, 16'h0, "R1");

    // R2 full loads
    wr(8'd0,  16'hA5C3, "R2"); wr(8'd16, 16'h0F0F, "R2");
    wr(8'd32, 16'hF00F, "R2"); wr(8'd48, 16'h1234, "R2");
    wr(8'd52, 16'h8001, "R2"); wr(8'd56, 16'h00FF, "R2");
    wr(8'd60, 16'hFF00, "R2"); wr(8'd64, 16'hCAFE, "R2");
    checkAll("R2");

    // R6 reads of every valid offset, back to back
    for (int i = 0; i < 17; i++) rd(8'(i * 4), "R6");

    // R3 clear aliases
    wr(8'd4,  16'h0081, "R3"); wr(8'd20, 16'h0F00, "R3"); wr(8'd36, 16'h8001, "R3");
    checkAll("R3");
    // R4 set aliases
    wr(8'd8,  16'h1000, "R4"); wr(8'd24, 16'hF000, "R4"); wr(8'd40, 16'h0660, "R4");
    checkAll("R4");
    // R5 toggle aliases
    wr(8'd12, 16'hFFFF, "R5"); wr(8'd28, 16'h5555, "R5"); wr(8'd44, 16'h00F0, "R5");
    checkAll("R5");
    // R6 alias reads return the base register
    rd(8'd12, "R6"); rd(8'd20, "R6"); rd(8'd44, "R6"); rd(8'd56, "R6");

    // R8 pin update alone, then alongside a write to another register
    drive(1'b0, 1'b0, 8'd0, 16'h0, 1'b1, 16'h3C3C, "R8");
    checkAll("R8");
    drive(1'b1, 1'b1, 8'd48, 16'h7777, 1'b1, 16'hC3C3, "R8");
    checkAll("R8");

    // R9 bus write to the data group wins over the pin update
    drive(1'b1, 1'b1, 8'd8, 16'h0001, 1'b1, 16'hFFFF, "R9");
    checkAll("R9");
    drive(1'b1, 1'b1, 8'd0, 16'h2468, 1'b1, 16'hFFFF, "R9");
    checkAll("R9");

    // R7 invalid accesses
    wr(8'd68, 16'hFFFF, "R7");
    checkAll("R7");
    wr(8'd2,  16'hFFFF, "R7");
    rd(8'd200, "R7");
    rd(8'd5,   "R7");
    checkAll("R7");
    wr(8'd16, 16'h0101, "R7");
    rd(8'd0, "R7");
    checkAll("R7");

    repeat (2) @(negedge clk);
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

endmodule